// File: doc/BRIEF.md
# Configurable CAN Fault Confinement Controller

This block keeps the transmit-side fault-confinement standing of a single CAN node. A frame-level controller pulses one input when a transmission fails and another when a transmission completes cleanly. From these pulses the block maintains a transmit error count and classifies the node as error-active, error-passive or bus-off. In bus-off the node must stop driving the bus. It is readmitted only after the sampled bus has shown a fixed number of runs of eleven recessive bits. One bus bit is presented per clock.

A one-bit profile input chooses between two sets of limits. The standard set uses a passive limit of 127, a bus-off limit of 255 and 128 recovery runs. The halved set uses 63, 127 and 64 runs, so a node under attack is isolated in about half the errors and readmitted in half the time. The profile is followed only while the node is error-active. Once an escalation has begun, its limits are frozen until the node is error-active again.

Top module: `fc_confine_top`

## Requirements
- R1: After a synchronous reset, `state_o` is 0, `tec_o` is 0, `bus_off_o` is 0 and `recovered_o` is 0. The state codes are 0 for error-active, 1 for error-passive and 2 for bus-off, and code 3 never appears.
- R2: A `tx_err_i` pulse outside bus-off adds 8 to `tec_o`. When `tx_err_i` and `tx_ok_i` are both high in the same cycle, the error wins.
- R3: A `tx_ok_i` pulse without `tx_err_i`, outside bus-off, subtracts 1 from `tec_o`. At 0 the count stays at 0.
- R4: Outside bus-off, the state is error-passive while `tec_o` exceeds the passive limit and error-active otherwise. The passive limit is 127 with `profile_i`=0 and 63 with `profile_i`=1.
- R5: When `tec_o` would exceed the bus-off limit, the state becomes bus-off and `bus_off_o` goes high. The bus-off limit is 255 with profile 0 and 127 with profile 1. While bus-off, `tx_err_i` and `tx_ok_i` leave `tec_o` unchanged.
- R6: In bus-off, the node returns to error-active on the clock that completes the required number of runs of 11 consecutive recessive bits (`bus_bit_i`=1). The number of runs is 128 with profile 0 and 64 with profile 1. On an all-recessive bus this takes 1408 or 704 clocks after the clock that entered bus-off.
- R7: A dominant bit (`bus_bit_i`=0) during recovery restarts the current 11-bit run. Runs already completed are kept.
- R8: On leaving bus-off, `tec_o` becomes 0, `bus_off_o` falls, and `recovered_o` is high for exactly one cycle.
- R9: `profile_i` is used only while the node is error-active. A change while error-passive or bus-off has no effect on limits or recovery length.
- R10: All outputs are registered. They reflect an input pulse at the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bus bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | One-cycle pulse: a transmission failed |
| tx_ok_i | input | 1 | One-cycle pulse: a transmission succeeded |
| bus_bit_i | input | 1 | Sampled bus level, 1 = recessive |
| profile_i | input | 1 | Limit set: 0 standard, 1 halved |
| state_o | output | 2 | Confinement state code |
| tec_o | output | 9 | Transmit error count |
| bus_off_o | output | 1 | Node isolated, must not drive the bus |
| recovered_o | output | 1 | One-cycle pulse on leaving bus-off |

## Verification
The hardest situation to reach is the final run of a recovery that an earlier dominant bit interrupted partway through a run. Only the exact cycle of readmission shows whether completed runs were kept and only the partial run was discarded. The stimulus drives the node into bus-off with the halved profile. It gives two full runs and part of a third, inserts one dominant bit, and then counts out the remaining recessive bits. It checks the state one cycle before and exactly at the expected exit. A second scenario switches the profile while the node is error-passive. The count there is already above the halved bus-off limit, so any premature use of the new profile shows at once.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_tec_counter.sv
module fc_tec_counter #(
  parameter int TEC_W   = 9,
  parameter int ERR_INC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             clr_i,
  output logic [TEC_W-1:0] tec_next_o,
  output logic [TEC_W-1:0] tec_q_o
);
  localparam logic [TEC_W-1:0] INC_V = TEC_W'(ERR_INC);
  localparam logic [TEC_W-1:0] MAX_V = '1;
  localparam logic [TEC_W-1:0] SAT_V = MAX_V - INC_V;

  logic [TEC_W-1:0] tec_q;

  always_comb begin
    tec_next_o = tec_q;
    if (clr_i)
      tec_next_o = '0;
    else if (inc_i)
      tec_next_o = (tec_q > SAT_V) ? MAX_V : tec_q + INC_V;
    else if (dec_i && tec_q != '0)
      tec_next_o = tec_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tec_q <= '0;
    else     tec_q <= tec_next_o;
  end

  assign tec_q_o = tec_q;

  // R2: a step below saturation moves the count by exactly the increment
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && tec_q <= SAT_V) |=> (tec_q == $past(tec_q) + INC_V));

  // R3: decrement never wraps below zero
  a_r3_floor: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !inc_i && !clr_i && tec_q == '0) |=> (tec_q == '0));
endmodule

// File: rtl/fc_recovery_timer.sv
module fc_recovery_timer #(
  parameter int RUN_LEN = 11,
  parameter int RUNS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              bit_i,
  input  logic [RUNS_W-1:0] target_i,
  output logic              done_o
);
  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0]  run_cnt;
  logic [RUNS_W-1:0] runs;
  logic              run_end;

  assign run_end = en_i && bit_i && (run_cnt == RUN_LAST);
  assign done_o  = run_end && (runs == target_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      run_cnt <= '0;
      runs    <= '0;
    end else if (!bit_i) begin
      run_cnt <= '0;
    end else if (run_end) begin
      run_cnt <= '0;
      runs    <= runs + 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R7: a dominant bit keeps the completed-run count
  a_r7_keep_runs: assert property (@(posedge clk) disable iff (rst)
    (en_i && !bit_i) |=> (runs == $past(runs)));

  // R7: the position inside a run stays within one run length
  a_r7_run_bound: assert property (@(posedge clk) disable iff (rst)
    (run_cnt <= RUN_LAST));
endmodule

// File: rtl/fc_confine_top.sv
module fc_confine_top #(
  parameter int TEC_W   = 9,
  parameter int ERR_INC = 8,
  parameter int RUN_LEN = 11,
  parameter int PASS_A  = 127,
  parameter int OFF_A   = 255,
  parameter int RUNS_A  = 128,
  parameter int PASS_B  = 63,
  parameter int OFF_B   = 127,
  parameter int RUNS_B  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             bus_bit_i,
  input  logic             profile_i,
  output logic [1:0]       state_o,
  output logic [TEC_W-1:0] tec_o,
  output logic             bus_off_o,
  output logic             recovered_o
);
  import fc_pkg::*;

  localparam int RUNS_MAX = (RUNS_A > RUNS_B) ? RUNS_A : RUNS_B;
  localparam int RUNS_W   = $clog2(RUNS_MAX + 1);

  fc_state_e        state_q, state_n;
  logic             prof_q, prof_sel;
  logic             bus_off_q, recovered_q;
  logic             in_off, rec_done;
  logic [TEC_W-1:0] tec_next, tec_q;
  logic [TEC_W-1:0] pass_thr, off_thr;
  logic [RUNS_W-1:0] runs_target;

  assign in_off   = (state_q == FC_BUSOFF);
  // limits follow the input only while error-active
  assign prof_sel = (state_q == FC_ACTIVE) ? profile_i : prof_q;

  always_comb begin
    if (prof_sel) begin
      pass_thr    = TEC_W'(PASS_B);
      off_thr     = TEC_W'(OFF_B);
      runs_target = RUNS_W'(RUNS_B);
    end else begin
      pass_thr    = TEC_W'(PASS_A);
      off_thr     = TEC_W'(OFF_A);
      runs_target = RUNS_W'(RUNS_A);
    end
  end

  fc_tec_counter #(.TEC_W(TEC_W), .ERR_INC(ERR_INC)) u_tec (
    .clk        (clk),
    .rst        (rst),
    .inc_i      (tx_err_i && !in_off),
    .dec_i      (tx_ok_i && !tx_err_i && !in_off),
    .clr_i      (rec_done),
    .tec_next_o (tec_next),
    .tec_q_o    (tec_q)
  );

  fc_recovery_timer #(.RUN_LEN(RUN_LEN), .RUNS_W(RUNS_W)) u_rec (
    .clk      (clk),
    .rst      (rst),
    .en_i     (in_off),
    .bit_i    (bus_bit_i),
    .target_i (runs_target),
    .done_o   (rec_done)
  );

  always_comb begin
    if (in_off)
      state_n = rec_done ? FC_ACTIVE : FC_BUSOFF;
    else if (tec_next > off_thr)
      state_n = FC_BUSOFF;
    else if (tec_next > pass_thr)
      state_n = FC_PASSIVE;
    else
      state_n = FC_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= FC_ACTIVE;
      prof_q      <= 1'b0;
      bus_off_q   <= 1'b0;
      recovered_q <= 1'b0;
    end else begin
      state_q     <= state_n;
      prof_q      <= prof_sel;
      bus_off_q   <= (state_n == FC_BUSOFF);
      recovered_q <= rec_done;
    end
  end

  assign state_o     = state_q;
  assign tec_o       = tec_q;
  assign bus_off_o   = bus_off_q;
  assign recovered_o = recovered_q;

  // R1: only the three defined codes appear
  a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd3));

  // R5: the isolation flag agrees with the state code
  a_r5_flag_match: assert property (@(posedge clk) disable iff (rst)
    (bus_off_o == (state_o == 2'd2)));

  // R5: count frozen while isolated, cleared on exit (R8)
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    bus_off_o |=> (bus_off_o ? (tec_o == $past(tec_o)) : (tec_o == '0)));

  // R8: readmission pulse only after bus-off, lands error-active with zero count
  a_r8_exit: assert property (@(posedge clk) disable iff (rst)
    recovered_o |-> (state_o == 2'd0 && tec_o == '0 && $past(bus_off_o)));

  // R8: the pulse lasts one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    recovered_o |=> !recovered_o);

  // R9: profile frozen outside error-active
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd0) |=> $stable(prof_q));
endmodule

// File: tb/test_fc_confine_top.sv
module test_fc_confine_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       err;
    logic       ok;
    logic [1:0] st;
    logic [8:0] tec;
  } vec_t;

  // R2, R3, R10: each row is one clock; outputs checked right after that edge
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 2'd0, 9'd8},
    '{1'b1, 1'b0, 2'd0, 9'd16},
    '{1'b0, 1'b1, 2'd0, 9'd15},
    '{1'b1, 1'b1, 2'd0, 9'd23},
    '{1'b0, 1'b0, 2'd0, 9'd23},
    '{1'b0, 1'b1, 2'd0, 9'd22}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_err = 1'b0, tx_ok = 1'b0, bus_bit = 1'b1, profile = 1'b0;
  logic [1:0] state;
  logic [8:0] tec;
  logic       bus_off, recovered;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  fc_confine_top i_fc_confine_top (
    .clk(clk), .rst(rst), .tx_err_i(tx_err), .tx_ok_i(tx_ok),
    .bus_bit_i(bus_bit), .profile_i(profile), .state_o(state),
    .tec_o(tec), .bus_off_o(bus_off), .recovered_o(recovered)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic e, input logic o, input logic b);
    tx_err = e; tx_ok = o; bus_bit = b;
    @(posedge clk); #1;
    tx_err = 1'b0; tx_ok = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 state after reset", state, 0);
    chk("R1 tec after reset", tec, 0);
    chk("R1 bus_off after reset", bus_off, 0);
    chk("R1 recovered after reset", recovered, 0);

    for (int i = 0; i < 6; i++) begin
      cyc(VECS[i].err, VECS[i].ok, 1'b1);
      chk($sformatf("R2/R3/R10 vec %0d tec", i), tec, VECS[i].tec);
      chk($sformatf("R10 vec %0d state", i), state, VECS[i].st);
    end

    repeat (30) cyc(1'b0, 1'b1, 1'b1);
    chk("R3 floor at zero", tec, 0);

    repeat (15) cyc(1'b1, 1'b0, 1'b1);
    chk("R4 A tec 120", tec, 120);
    chk("R4 A still active at 120", state, 0);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R4 A passive above 127", state, 1);
    cyc(1'b0, 1'b1, 1'b1);
    chk("R4 A back to active at 127", state, 0);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R4 A passive at 135", state, 1);

    profile = 1'b1;
    cyc(1'b0, 1'b1, 1'b1);
    chk("R9 profile ignored while passive", state, 1);
    chk("R9 tec 134", tec, 134);

    repeat (15) cyc(1'b1, 1'b0, 1'b1);
    chk("R5 A passive at 254", state, 1);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R5 A bus-off above 255", state, 2);
    chk("R5 A bus_off flag", bus_off, 1);
    chk("R5 A tec 262", tec, 262);

    cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 1'b1);
    chk("R5 pulses ignored in bus-off", tec, 262);

    repeat (1404) cyc(1'b0, 1'b0, 1'b1);
    chk("R6 A still bus-off at 1407", state, 2);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R6 A active at 1408", state, 0);
    chk("R8 recovered pulse", recovered, 1);
    chk("R8 tec cleared", tec, 0);
    chk("R8 bus_off cleared", bus_off, 0);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R8 pulse one cycle", recovered, 0);

    repeat (7) cyc(1'b1, 1'b0, 1'b1);
    chk("R4 B active at 56", state, 0);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R4 B passive above 63", state, 1);
    repeat (7) cyc(1'b1, 1'b0, 1'b1);
    chk("R5 B passive at 120", state, 1);
    cyc(1'b1, 1'b0, 1'b1);
    chk("R5 B bus-off above 127", state, 2);
    chk("R5 B tec 128", tec, 128);

    profile = 1'b0;
    repeat (27) cyc(1'b0, 1'b0, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    repeat (681) cyc(1'b0, 1'b0, 1'b1);
    chk("R7 still bus-off one bit early", state, 2);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R7/R6 B active after kept runs", state, 0);
    chk("R8 B recovered pulse", recovered, 1);
    cyc(1'b0, 1'b0, 1'b1);
    chk("R8 B pulse one cycle", recovered, 0);

    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule